// File: doc/BRIEF.md
# Linked-List DMA Channel Engine

This block is the sequencer of one DMA channel that moves words from main memory to a peripheral. In chain mode it follows a list of packets held in memory. Each packet opens with a single header word. The top eight bits of the header give the payload length in words, and the low 24 bits point at the next packet. The engine fetches the header, waits a fixed fetch cost, and streams the payload words to the peripheral. It then moves on to the next header. It stops when it finds a pointer with its end bit set. In block mode it sends a number of equal, back-to-back blocks that start at the base address.

Software loads a base address and a block control word and then writes the channel control word. A rising run bit starts the channel. Memory answers read requests over a request/valid port with any latency of one cycle or more. The peripheral reports through a ready input whether a new packet or block may begin. The engine signals the end of a transfer with a one-cycle done pulse and by clearing the run and trigger bits of the control word. Software may also clear the run bit during a transfer. The engine then finishes the packet in progress and stops quietly.

Top module: `llch_engine`

## Requirements
- R1: After reset, busy, done, mem_rd and per_wr are low and ctl_q is zero.
- R2: A control write is stored masked with 0x71770703. When idle, a write that takes bit 24 from 0 to 1 starts the channel. The next address is loaded with base_addr & 0x1FFFFC, the block count is loaded from blk_ctl[31:16], and busy is high from the next cycle.
- R3: Chain mode applies when ctl bits 10 and 0 are both set. The header is read at the next address masked to 0x1FFFFC. Header bits 31:24 are the payload word count and bits 23:0 are the new next address.
- R4: Payload words are read starting at the header address plus 4, stepping by 4 and wrapping within 21 address bits. Each word is one memory read followed by one per_wr strobe that carries the read data, in the cycle after mem_rvalid. mem_rd is never high in two consecutive cycles.
- R5: After a header arrives, the engine waits 15 cycles if its count is nonzero and 10 cycles if the count is zero. A zero-count packet goes on straight to the next header. With one-cycle memory, the gap from a header read to the first payload read is 17 cycles. The gap from a zero-count header read to the next header read is 13 cycles.
- R6: The end check runs each time the word counter is zero: if bit 23 of the next address is set, ctl bits 24 and 28 clear, done pulses for exactly one cycle, and busy falls in that same cycle.
- R7: Block mode applies when ctl bit 10 or bit 0 is clear. It sends blk_ctl[31:16] blocks of blk_ctl[15:0] words each, contiguous from the base address. After the last block the next address becomes 0xFFFFFF.
- R8: While per_ready is low, no header read and no first block read is issued, and busy stays high.
- R9: If software clears bit 24 during a packet, that packet completes. The channel then goes idle without a done pulse.
- R10: If a control write falls in the completion cycle, the written bits are kept except bits 24 and 28, which end up cleared, and done still pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_addr | input | 24 | Base address register |
| blk_ctl | input | 32 | Block count (31:16) and block size (15:0) |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 32 | Control register write data |
| ctl_q | output | 32 | Current control register value |
| mem_rd | output | 1 | Memory read request, one cycle per word |
| mem_addr | output | 21 | Memory byte address |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rdata | input | 32 | Memory read data |
| per_ready | input | 1 | Peripheral can take a new packet or block |
| per_wr | output | 1 | Peripheral write strobe |
| per_wdata | output | 32 | Peripheral write data |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Channel active |

## Verification
The hardware clear of the run and trigger bits on completion can fall in the same cycle as a software write to the control register. The bench provokes this by watching for the last peripheral strobe of a one-word block transfer. That strobe marks the cycle in which the engine evaluates the end marker, and the bench writes the control word in exactly that cycle, with a new mode bit and the run bit still set. The result is judged one cycle later: done must be high, busy low, and ctl_q must hold the new mode bit with bits 24 and 28 cleared.

// File: rtl/llch_pkg.sv
package llch_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DECIDE,
    ST_HREQ,
    ST_HWAIT,
    ST_HCOST,
    ST_RREQ,
    ST_RWAIT
  } llch_state_e;

  localparam int unsigned CTL_RUN_BIT   = 24;
  localparam int unsigned CTL_TRIG_BIT  = 28;
  localparam int unsigned CTL_CHAIN_BIT = 10;
  localparam int unsigned CTL_DIR_BIT   = 0;

  // mask keeping the low aw bits
  function automatic logic [31:0] low_mask(input int unsigned aw);
    return (32'd1 << aw) - 32'd1;
  endfunction

  // add with wrap inside an aw-bit address space
  function automatic logic [31:0] wrap_add(input logic [31:0] a,
                                           input logic [31:0] inc,
                                           input int unsigned aw);
    return (a + inc) & low_mask(aw);
  endfunction

  // word-aligned address inside the aw-bit space
  function automatic logic [31:0] word_align(input logic [31:0] a,
                                             input int unsigned aw);
    return a & low_mask(aw) & ~32'd3;
  endfunction

  // idle cycles spent after a header arrives
  function automatic logic [31:0] hdr_cost(input logic [31:0] cnt,
                                           input int unsigned nz_cost,
                                           input int unsigned z_cost);
    return (cnt != 32'd0) ? nz_cost : z_cost;
  endfunction

endpackage

// File: rtl/llch_ctl_reg.sv
module llch_ctl_reg #(
  parameter int unsigned      DATA_W   = 32,
  parameter logic [31:0]      CTL_MASK = 32'h7177_0703
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              idle,
  input  logic              hw_clear,
  output logic [DATA_W-1:0] q,
  output logic              start_evt
);
  import llch_pkg::*;

  logic [DATA_W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (wr) q_nxt = wdata & CTL_MASK[DATA_W-1:0];
    // completion clear wins over a simultaneous write
    if (hw_clear) begin
      q_nxt[CTL_RUN_BIT]  = 1'b0;
      q_nxt[CTL_TRIG_BIT] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  assign start_evt = wr && wdata[CTL_RUN_BIT] && !q[CTL_RUN_BIT] && idle;

endmodule

// File: rtl/llch_cost_timer.sv
module llch_cost_timer #(
  parameter int unsigned TMR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TMR_W-1:0] val,
  output logic             expired
);
  logic [TMR_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt <= '0;
    else if (load)          cnt <= val;
    else if (cnt != '0)     cnt <= cnt - TMR_W'(1);
  end

  assign expired = (cnt == TMR_W'(1));

endmodule

// File: rtl/llch_seq.sv
module llch_seq #(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 21,
  parameter int unsigned PTR_W       = 24,
  parameter int unsigned LEN_W       = 8,
  parameter int unsigned BLK_W       = 16,
  parameter int unsigned HDR_COST_NZ = 15,
  parameter int unsigned HDR_COST_Z  = 10,
  parameter int unsigned TMR_W       = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              run,
  input  logic              chain_mode,
  input  logic [PTR_W-1:0]  base_addr,
  input  logic [2*BLK_W-1:0] blk_ctl,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              per_ready,
  input  logic              tmr_expired,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              per_wr,
  output logic [DATA_W-1:0] per_wdata,
  output logic              complete_evt,
  output logic              tmr_load,
  output logic [TMR_W-1:0]  tmr_val,
  output logic              busy
);
  import llch_pkg::*;

  localparam int unsigned CNT_W   = (BLK_W > LEN_W) ? BLK_W : LEN_W;
  localparam int unsigned END_BIT = PTR_W - 1;

  llch_state_e       st;
  logic [PTR_W-1:0]  nxt;
  logic [ADDR_W-1:0] cur;
  logic [CNT_W-1:0]  wcnt;
  logic [BLK_W-1:0]  blk_left;

  // arithmetic helpers on 32-bit values, sliced afterwards
  logic [31:0] base_al32, nxt_al32, cur_step32, blk_adv32, cost32;
  logic [BLK_W-1:0] blk_size;
  logic [LEN_W-1:0] hdr_len;
  logic [PTR_W-1:0] hdr_ptr;
  logic             pkt_begin;

  assign blk_size = blk_ctl[BLK_W-1:0];
  assign hdr_len  = mem_rdata[DATA_W-1 -: LEN_W];
  assign hdr_ptr  = mem_rdata[PTR_W-1:0];

  always_comb begin
    base_al32  = word_align({{(32-PTR_W){1'b0}}, base_addr}, ADDR_W);
    nxt_al32   = word_align({{(32-PTR_W){1'b0}}, nxt}, ADDR_W);
    cur_step32 = wrap_add({{(32-ADDR_W){1'b0}}, cur}, 32'd4, ADDR_W);
    blk_adv32  = wrap_add(nxt_al32, {{(32-BLK_W){1'b0}}, blk_size} << 2, ADDR_W);
    cost32     = hdr_cost({{(32-LEN_W){1'b0}}, hdr_len}, HDR_COST_NZ, HDR_COST_Z);
  end

  assign complete_evt = (st == ST_DECIDE) && run && nxt[END_BIT];
  assign pkt_begin    = (st == ST_DECIDE) && run && !nxt[END_BIT] && per_ready;
  assign tmr_load     = (st == ST_HWAIT) && mem_rvalid;
  assign tmr_val      = cost32[TMR_W-1:0];
  assign mem_rd       = (st == ST_HREQ) || (st == ST_RREQ);
  assign mem_addr     = cur;
  assign busy         = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      nxt       <= '0;
      cur       <= '0;
      wcnt      <= '0;
      blk_left  <= '0;
      per_wr    <= 1'b0;
      per_wdata <= '0;
    end else begin
      per_wr <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            nxt      <= {{(PTR_W-ADDR_W){1'b0}}, base_al32[ADDR_W-1:0]};
            blk_left <= blk_ctl[2*BLK_W-1:BLK_W];
            wcnt     <= '0;
            st       <= ST_DECIDE;
          end
        end
        ST_DECIDE: begin
          if (!run || nxt[END_BIT]) begin
            st <= ST_IDLE;
          end else if (pkt_begin) begin
            cur <= nxt_al32[ADDR_W-1:0];
            if (chain_mode) begin
              st <= ST_HREQ;
            end else begin
              wcnt     <= {{(CNT_W-BLK_W){1'b0}}, blk_size};
              blk_left <= blk_left - BLK_W'(1);
              if (blk_left == BLK_W'(1)) nxt <= '1;
              else nxt <= {{(PTR_W-ADDR_W){1'b0}}, blk_adv32[ADDR_W-1:0]};
              st <= (blk_size != '0) ? ST_RREQ : ST_DECIDE;
            end
          end
        end
        ST_HREQ: st <= ST_HWAIT;
        ST_HWAIT: begin
          if (mem_rvalid) begin
            wcnt <= {{(CNT_W-LEN_W){1'b0}}, hdr_len};
            nxt  <= hdr_ptr;
            cur  <= cur_step32[ADDR_W-1:0];
            st   <= ST_HCOST;
          end
        end
        ST_HCOST: begin
          if (tmr_expired) st <= (wcnt != '0) ? ST_RREQ : ST_DECIDE;
        end
        ST_RREQ: st <= ST_RWAIT;
        ST_RWAIT: begin
          if (mem_rvalid) begin
            per_wr    <= 1'b1;
            per_wdata <= mem_rdata;
            cur       <= cur_step32[ADDR_W-1:0];
            wcnt      <= wcnt - CNT_W'(1);
            st        <= (wcnt == CNT_W'(1)) ? ST_DECIDE : ST_RREQ;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/llch_engine.sv
module llch_engine #(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 21,
  parameter int unsigned PTR_W       = 24,
  parameter int unsigned LEN_W       = 8,
  parameter int unsigned BLK_W       = 16,
  parameter int unsigned HDR_COST_NZ = 15,
  parameter int unsigned HDR_COST_Z  = 10,
  parameter logic [31:0] CTL_MASK    = 32'h7177_0703
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PTR_W-1:0]    base_addr,
  input  logic [2*BLK_W-1:0]  blk_ctl,
  input  logic                ctl_wr,
  input  logic [DATA_W-1:0]   ctl_wdata,
  output logic [DATA_W-1:0]   ctl_q,
  output logic                mem_rd,
  output logic [ADDR_W-1:0]   mem_addr,
  input  logic                mem_rvalid,
  input  logic [DATA_W-1:0]   mem_rdata,
  input  logic                per_ready,
  output logic                per_wr,
  output logic [DATA_W-1:0]   per_wdata,
  output logic                done,
  output logic                busy
);
  import llch_pkg::*;

  localparam int unsigned COST_MAX = (HDR_COST_NZ > HDR_COST_Z) ? HDR_COST_NZ : HDR_COST_Z;
  localparam int unsigned TMR_W    = $clog2(COST_MAX + 1);

  logic             start_evt;
  logic             complete_evt;
  logic             tmr_load;
  logic [TMR_W-1:0] tmr_val;
  logic             tmr_expired;
  logic             chain_mode;

  assign chain_mode = ctl_q[CTL_CHAIN_BIT] && ctl_q[CTL_DIR_BIT];

  llch_ctl_reg #(
    .DATA_W   (DATA_W),
    .CTL_MASK (CTL_MASK)
  ) i_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (ctl_wr),
    .wdata     (ctl_wdata),
    .idle      (!busy),
    .hw_clear  (complete_evt),
    .q         (ctl_q),
    .start_evt (start_evt)
  );

  llch_cost_timer #(
    .TMR_W (TMR_W)
  ) i_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .val     (tmr_val),
    .expired (tmr_expired)
  );

  llch_seq #(
    .DATA_W      (DATA_W),
    .ADDR_W      (ADDR_W),
    .PTR_W       (PTR_W),
    .LEN_W       (LEN_W),
    .BLK_W       (BLK_W),
    .HDR_COST_NZ (HDR_COST_NZ),
    .HDR_COST_Z  (HDR_COST_Z),
    .TMR_W       (TMR_W)
  ) i_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start_evt),
    .run          (ctl_q[CTL_RUN_BIT]),
    .chain_mode   (chain_mode),
    .base_addr    (base_addr),
    .blk_ctl      (blk_ctl),
    .mem_rvalid   (mem_rvalid),
    .mem_rdata    (mem_rdata),
    .per_ready    (per_ready),
    .tmr_expired  (tmr_expired),
    .mem_rd       (mem_rd),
    .mem_addr     (mem_addr),
    .per_wr       (per_wr),
    .per_wdata    (per_wdata),
    .complete_evt (complete_evt),
    .tmr_load     (tmr_load),
    .tmr_val      (tmr_val),
    .busy         (busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) done <= 1'b0;
    else        done <= complete_evt;
  end

endmodule

// File: rtl/llch_checker.sv
module llch_checker #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 21
) (
  input logic              clk,
  input logic              rst_n,
  input logic              done,
  input logic              busy,
  input logic              mem_rd,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              per_wr,
  input logic [DATA_W-1:0] ctl_q,
  input logic              start_evt
);

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  done_clears_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!ctl_q[24] && !ctl_q[28]));

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> busy);

  // R4
  addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (mem_addr[1:0] == 2'b00));

  // R4
  single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);

  // R4
  write_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    per_wr |-> busy);

endmodule

bind llch_engine llch_checker #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) i_llch_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .done      (done),
  .busy      (busy),
  .mem_rd    (mem_rd),
  .mem_addr  (mem_addr),
  .per_wr    (per_wr),
  .ctl_q     (ctl_q),
  .start_evt (start_evt)
);

// File: tb/test_llch_engine.sv
module test_llch_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] base_addr = '0;
  logic [31:0] blk_ctl = '0;
  logic        ctl_wr = 1'b0;
  logic [31:0] ctl_wdata = '0;
  logic [31:0] ctl_q;
  logic        mem_rd;
  logic [20:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        per_ready = 1'b1;
  logic        per_wr;
  logic [31:0] per_wdata;
  logic        done;
  logic        busy;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  logic [31:0] mem [0:511];
  logic [31:0] wlog [0:255];
  logic [20:0] alog [0:255];
  int          tlog [0:255];
  int wn = 0, an = 0, dn = 0;

  always #5 clk = ~clk;

  llch_engine i_llch_engine (
    .clk(clk), .rst_n(rst_n), .base_addr(base_addr), .blk_ctl(blk_ctl),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_q(ctl_q),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .per_ready(per_ready), .per_wr(per_wr),
    .per_wdata(per_wdata), .done(done), .busy(busy)
  );

  // one-cycle memory model
  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_rvalid <= mem_rd;
    mem_rdata  <= mem[mem_addr[10:2]];
  end

  always @(negedge clk) begin
    if (per_wr && wn < 256) begin wlog[wn] = per_wdata; wn = wn + 1; end
    if (mem_rd && an < 256) begin alog[an] = mem_addr; tlog[an] = cyc; an = an + 1; end
    if (done) dn = dn + 1;
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", rq, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic [31:0] v);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_wdata = v;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic wait_idle(input string rq);
    int k;
    k = 0;
    while (busy && k < 2000) begin @(negedge clk); k++; end
    chk({rq, " engine returned to idle"}, {31'd0, busy}, 32'd0);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 busy after reset", {31'd0, busy}, 32'd0);
    chk("R1 done after reset", {31'd0, done}, 32'd0);
    chk("R1 mem_rd after reset", {31'd0, mem_rd}, 32'd0);
    chk("R1 per_wr after reset", {31'd0, per_wr}, 32'd0);
    chk("R1 ctl_q after reset", ctl_q, 32'd0);
  endtask

  task automatic t_chain();
    int w0, a0, d0;
    mem[12'h100 >> 2] = 32'h0200_0200;    // len 2, next 0x200
    mem[12'h104 >> 2] = 32'hAAAA_0001;
    mem[12'h108 >> 2] = 32'hAAAA_0002;
    mem[12'h200 >> 2] = 32'h0000_0300;    // len 0, next 0x300
    mem[12'h300 >> 2] = 32'h0180_0000;    // len 1, next = end marker
    mem[12'h304 >> 2] = 32'hAAAA_0003;
    w0 = wn; a0 = an; d0 = dn;
    base_addr = 24'h000103;
    wr_ctl(32'h1108_0401);
    chk("R2 control write masked", ctl_q, 32'h1100_0401);
    chk("R2 busy after start", {31'd0, busy}, 32'd1);
    wait_idle("R6");
    chk("R3 payload count", wn - w0, 3);
    chk("R4 payload word 0", wlog[w0], 32'hAAAA_0001);
    chk("R4 payload word 1", wlog[w0+1], 32'hAAAA_0002);
    chk("R3 payload after zero packet", wlog[w0+2], 32'hAAAA_0003);
    chk("R3 first header address", {11'd0, alog[a0]}, 32'h100);
    chk("R4 first payload address", {11'd0, alog[a0+1]}, 32'h104);
    chk("R4 second payload address", {11'd0, alog[a0+2]}, 32'h108);
    chk("R5 header to payload gap", tlog[a0+1] - tlog[a0], 17);
    chk("R3 zero header address", {11'd0, alog[a0+3]}, 32'h200);
    chk("R5 zero header to next header gap", tlog[a0+4] - tlog[a0+3], 13);
    chk("R3 third header address", {11'd0, alog[a0+4]}, 32'h300);
    chk("R6 done pulses once", dn - d0, 1);
    chk("R6 run and trigger cleared", ctl_q, 32'h0000_0401);
  endtask

  task automatic t_block(input logic [31:0] ctl, input logic [23:0] base,
                         input int nblk, input int bsize, input logic [31:0] ctl_end);
    int w0, a0, d0, n;
    n = nblk * bsize;
    for (int i = 0; i < n; i++) mem[(base >> 2) + i] = 32'hB000_0000 + base + i;
    w0 = wn; a0 = an; d0 = dn;
    base_addr = base;
    blk_ctl = {nblk[15:0], bsize[15:0]};
    wr_ctl(ctl);
    wait_idle("R7");
    chk("R7 block word count", wn - w0, n);
    for (int i = 0; i < n; i++) begin
      chk("R7 block read address", {11'd0, alog[a0+i]}, base + 4*i);
      chk("R7 block data", wlog[w0+i], 32'hB000_0000 + base + i);
    end
    chk("R6 block done once", dn - d0, 1);
    chk("R6 block ctl after end", ctl_q, ctl_end);
  endtask

  task automatic t_wrap();
    int w0, a0;
    mem[510] = 32'h0280_0000;   // header at 0x1FFFF8: len 2, end next
    mem[511] = 32'hCCCC_0001;   // 0x1FFFFC
    mem[0]   = 32'hCCCC_0002;   // 0x000000 after wrap
    w0 = wn; a0 = an;
    base_addr = 24'hFFFFF8;     // masked to 0x1FFFF8
    wr_ctl(32'h0100_0401);
    wait_idle("R4");
    chk("R4 wrap header address", {11'd0, alog[a0]}, 32'h1F_FFF8);
    chk("R4 wrap payload address 0", {11'd0, alog[a0+1]}, 32'h1F_FFFC);
    chk("R4 wrap payload address 1", {11'd0, alog[a0+2]}, 32'h0);
    chk("R4 wrap data 1", wlog[w0+1], 32'hCCCC_0002);
  endtask

  task automatic t_ready();
    int w0, a0;
    mem[12'h600 >> 2] = 32'h0180_0000;
    mem[12'h604 >> 2] = 32'hDDDD_0001;
    w0 = wn; a0 = an;
    per_ready = 1'b0;
    base_addr = 24'h000600;
    wr_ctl(32'h0100_0401);
    repeat (30) @(negedge clk);
    chk("R8 no read while not ready", an - a0, 0);
    chk("R8 busy while not ready", {31'd0, busy}, 32'd1);
    per_ready = 1'b1;
    wait_idle("R8");
    chk("R8 packet sent after ready", wn - w0, 1);
    chk("R8 packet data", wlog[w0], 32'hDDDD_0001);
  endtask

  task automatic t_cancel();
    int w0, d0, k;
    mem[12'h400 >> 2] = 32'h0400_0500;
    for (int i = 1; i <= 4; i++) mem[(12'h400 >> 2) + i] = 32'hEEEE_0000 + i;
    mem[12'h500 >> 2] = 32'h0480_0000;
    for (int i = 1; i <= 4; i++) mem[(12'h500 >> 2) + i] = 32'hFFFF_0000 + i;
    w0 = wn; d0 = dn;
    base_addr = 24'h000400;
    wr_ctl(32'h0100_0401);
    k = 0;
    while (!per_wr && k < 200) begin @(negedge clk); k++; end
    wr_ctl(32'h0000_0401);
    wait_idle("R9");
    chk("R9 current packet finished", wn - w0, 4);
    chk("R9 last word of first packet", wlog[w0+3], 32'hEEEE_0004);
    chk("R9 no done on cancel", dn - d0, 0);
    chk("R9 ctl after cancel", ctl_q, 32'h0000_0401);
  endtask

  task automatic t_collide();
    int k;
    mem[12'h040 >> 2] = 32'hC011_1DE0;
    base_addr = 24'h000040;
    blk_ctl = 32'h0001_0001;
    wr_ctl(32'h1100_0001);
    k = 0;
    while (!per_wr && k < 200) begin @(negedge clk); k++; end
    // this cycle is the end check; write the control word now
    ctl_wr = 1'b1; ctl_wdata = 32'h1100_0401;
    @(negedge clk);
    ctl_wr = 1'b0;
    chk("R10 done in collision", {31'd0, done}, 32'd1);
    chk("R10 ctl keeps written bits", ctl_q, 32'h0000_0401);
    chk("R10 idle after collision", {31'd0, busy}, 32'd0);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_chain();
    t_block(32'h0100_0001, 24'h000040, 3, 2, 32'h0000_0001);
    t_block(32'h0100_0400, 24'h000080, 1, 2, 32'h0000_0400);
    t_wrap();
    t_ready();
    t_cancel();
    t_collide();
    finish_run();
  end

endmodule